// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master driven by a host through a byte-wide register file. The host writes bytes into a small transmit queue. The block sends them one after another on the serial data-out line with the clock polarity, clock phase, bit order and serial clock rate chosen by the host. Every byte received on the serial data-in line is placed in a receive data register. A ready flag and an optional interrupt tell the host that a new byte is waiting.

The controller is built around a three-state engine:

- **ST_IDLE**: no frame is in progress.
- **ST_SHIFT**: a byte is being clocked; one serial clock edge occurs every half period.
- **ST_HOLD**: the slave select stays asserted for one half period after the last edge.

The engine moves between these states as follows:

- **IDLE→SHIFT** happens when the queue is not empty and the controller is enabled. The head byte is popped at this point.
- **SHIFT→SHIFT** is taken on the sixteenth edge of a byte when another byte is queued. That byte is popped and clocked out with no gap.
- **SHIFT→HOLD** is taken on the sixteenth edge when the queue is empty.
- **HOLD→IDLE** is taken after one more half period.
- **any→IDLE** is forced while the controller is disabled.

Slave select runs in one of two modes. In automatic mode it is asserted for the whole frame. In manual mode the host drives the pin directly from a configuration bit.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00, the divider register reads 0xFF, the status register reads 0x00, ss_n is 1, sclk is 0 and irq is 0.
- R2: The registers are decoded from bus_addr as follows: configuration at 0x00, status at 0x01, divider at 0x02, transmit queue at 0x08 (write only) and receive data at 0x10 (read only). The configuration and divider registers read back the value last written.
- R3: One half serial clock period is 2^d system cycles, where d is the divider value clamped to MAX_DIV_LOG.
- R4: Configuration bit 2 (CPOL) sets the idle level of sclk. Configuration bit 3 (CPHA) selects when data is sampled:
  - With CPHA=0 data is sampled on the first edge of each bit pair and changed on the second.
  - With CPHA=1 data is changed on the first edge and sampled on the second.
- R5: Configuration bit 4 set sends and receives the least significant bit first. When it is clear, the most significant bit goes first.
- R6: At the end of each byte the received value is loaded into the receive data register and status bit 0 is set. Status bit 0 is cleared by a read of 0x10 or by writing 1 to status bit 0.
- R7: irq is 1 exactly when status bit 0 and configuration bit 1 are both 1.
- R8: The transmit queue holds FIFO_DEPTH (8) bytes, and a write to a full queue is dropped. Queued bytes are sent in write order, back to back within one frame.
- R9: Status bit 1 is 1 while a frame is in progress. Status bit 2 is 1 while the queue holds at least FIFO_DEPTH/2 bytes.
- R10: In automatic mode (configuration bit 5 = 0), ss_n is low for exactly (16·n+1) half periods for a frame of n bytes. The first sclk edge comes one half period after ss_n falls.
- R11: When configuration bit 5 is 1, ss_n equals configuration bit 6, whether or not a frame is in progress.
- R12: While configuration bit 0 is 1, the engine returns to ST_IDLE within one cycle and holds it there. During this time sclk stays at the CPOL level, no byte is popped, and ss_n is 1 in automatic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Receive-ready interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench uses the default build: 8-bit data, an 8-entry queue and MAX_DIV_LOG=15. Serial data-out is looped back to serial data-in, so every received byte must equal the byte sent in both bit orders.

With divider values 0 to 2, the bench sweeps every combination of the four clock modes and both bit orders. It times the slave-select window exactly in system cycles. Divider values this small keep every frame to a few hundred cycles, which brings the full mode space, queue overflow, the half-full threshold and a mid-frame disable within one short run.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } eng_state_t;

    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h01;
    localparam logic [7:0] OFS_DIV    = 8'h02;
    localparam logic [7:0] OFS_TXQ    = 8'h08;
    localparam logic [7:0] OFS_RXD    = 8'h10;

    localparam int CFG_HALT   = 0;
    localparam int CFG_IRQEN  = 1;
    localparam int CFG_CPOL   = 2;
    localparam int CFG_CPHA   = 3;
    localparam int CFG_LSB    = 4;
    localparam int CFG_MANSEL = 5;
    localparam int CFG_SELLVL = 6;
    localparam int CFG_W      = 7;

endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [W-1:0]       data_i,
    input  logic               pop_i,
    output logic [W-1:0]       head_o,
    output logic [$clog2(DEPTH):0] count_o,
    output logic               full_o,
    output logic               empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full_o  = (cnt == (AW+1)'(DEPTH));
    assign empty_o = (cnt == '0);
    assign count_o = cnt;
    assign head_o  = mem[rp];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (full_o && cnt == $past(cnt))); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R8

endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
    import spi_ctl_pkg::*;
#(
    parameter int W           = 8,
    parameter int DIV_W       = 8,
    parameter int MAX_DIV_LOG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic             lsb_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             q_empty_i,
    input  logic [W-1:0]     q_head_i,
    input  logic             miso_i,
    output logic             pop_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             sel_o,
    output logic             done_o,
    output logic [W-1:0]     rx_o
);
    localparam int CNT_W  = MAX_DIV_LOG + 1;
    localparam int EFF_W  = $clog2(MAX_DIV_LOG + 1);
    localparam int EDGE_W = $clog2(2 * W);
    localparam int LAST_E = 2 * W - 1;

    eng_state_t st, st_nx;

    logic [CNT_W-1:0]  cnt, half_len;
    logic [EFF_W-1:0]  eff;
    logic [EDGE_W-1:0] edge_idx;
    logic [W-1:0]      tx_sr, rx_sr, rx_nx, rx_q;
    logic              sclk_q;
    logic              tick, last_edge, is_sample, is_shift;

    // half-period length, divider clamped to MAX_DIV_LOG
    always_comb begin
        if (div_i > DIV_W'(MAX_DIV_LOG)) eff = EFF_W'(MAX_DIV_LOG);
        else                             eff = EFF_W'(div_i);
        half_len = CNT_W'(1) << eff;
    end

    assign tick      = (cnt == half_len - 1'b1);
    assign last_edge = (edge_idx == EDGE_W'(LAST_E));
    assign is_sample = (edge_idx[0] == cpha_i);
    assign is_shift  = !is_sample && (edge_idx != '0) && !last_edge;
    assign rx_nx     = lsb_i ? {miso_i, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso_i};

    // next state and strobes
    always_comb begin
        st_nx  = st;
        pop_o  = 1'b0;
        done_o = 1'b0;
        if (halt_i) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (!q_empty_i) begin
                        pop_o = 1'b1;
                        st_nx = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick && last_edge) begin
                        done_o = 1'b1;
                        if (!q_empty_i) pop_o = 1'b1;
                        else            st_nx = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tick) st_nx = ST_IDLE;
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            edge_idx <= '0;
            sclk_q   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rx_q     <= '0;
        end else begin
            st <= st_nx;
            if (halt_i || st == ST_IDLE) begin
                sclk_q   <= cpol_i;
                cnt      <= '0;
                edge_idx <= '0;
            end else begin
                cnt <= tick ? '0 : cnt + 1'b1;
                if (st == ST_SHIFT && tick) begin
                    sclk_q   <= ~sclk_q;
                    edge_idx <= last_edge ? '0 : edge_idx + 1'b1;
                    if (is_sample) rx_sr <= rx_nx;
                    if (is_shift)  tx_sr <= lsb_i ? (tx_sr >> 1) : (tx_sr << 1);
                    if (last_edge) rx_q  <= is_sample ? rx_nx : rx_sr;
                end
            end
            if (pop_o) tx_sr <= q_head_i;
        end
    end

    // outputs
    always_comb begin
        sclk_o = sclk_q;
        mosi_o = lsb_i ? tx_sr[0] : tx_sr[W-1];
        sel_o  = (st != ST_IDLE);
        rx_o   = rx_q;
    end

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (sclk_o == $past(cpol_i)) && !sel_o); // R12
    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st == ST_IDLE) && $stable(cpol_i)) |-> (sclk_o == cpol_i)); // R4
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !halt_i && !tick) |=> (st == ST_HOLD)); // R10

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spi_ctl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 8,
    parameter int MAX_DIV_LOG = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    localparam int QC_W = $clog2(FIFO_DEPTH) + 1;
    localparam int HALF = FIFO_DEPTH / 2;

    logic [CFG_W-1:0]  cfg;
    logic [DATA_W-1:0] div;
    logic              rx_ready;
    logic              q_push, q_pop, q_full, q_empty;
    logic [DATA_W-1:0] q_head, rx_byte;
    logic [QC_W-1:0]   q_count;
    logic              eng_sel, eng_done, q_half;
    logic [DATA_W-1:0] status;

    assign q_push = bus_wr && (bus_addr == OFS_TXQ);
    assign q_half = (q_count >= QC_W'(HALF));
    assign status = {{(DATA_W-3){1'b0}}, q_half, eng_sel, rx_ready};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            div      <= '1;
            rx_ready <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_CFG) cfg <= bus_wdata[CFG_W-1:0];
            if (bus_wr && bus_addr == OFS_DIV) div <= bus_wdata;
            if (eng_done)
                rx_ready <= 1'b1;
            else if ((bus_rd && bus_addr == OFS_RXD) ||
                     (bus_wr && bus_addr == OFS_STATUS && bus_wdata[0]))
                rx_ready <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CFG:    bus_rdata = DATA_W'(cfg);
            OFS_STATUS: bus_rdata = status;
            OFS_DIV:    bus_rdata = div;
            OFS_RXD:    bus_rdata = rx_byte;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq  = rx_ready && cfg[CFG_IRQEN];
    assign ss_n = cfg[CFG_MANSEL] ? cfg[CFG_SELLVL] : !eng_sel;

    spi_ctl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .data_i  (bus_wdata),
        .pop_i   (q_pop),
        .head_o  (q_head),
        .count_o (q_count),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    spi_ctl_engine #(.W(DATA_W), .DIV_W(DATA_W), .MAX_DIV_LOG(MAX_DIV_LOG)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (cfg[CFG_HALT]),
        .cpol_i    (cfg[CFG_CPOL]),
        .cpha_i    (cfg[CFG_CPHA]),
        .lsb_i     (cfg[CFG_LSB]),
        .div_i     (div),
        .q_empty_i (q_empty),
        .q_head_i  (q_head),
        .miso_i    (miso),
        .pop_o     (q_pop),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .sel_o     (eng_sel),
        .done_o    (eng_done),
        .rx_o      (rx_byte)
    );

    AST_READY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(eng_done)); // R6
    AST_AUTO_SEL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg[CFG_HALT]) && cfg[CFG_HALT] && !cfg[CFG_MANSEL]) |-> ss_n); // R12
    AST_NO_POP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[CFG_HALT] |-> !q_pop); // R12
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QC_W'(FIFO_DEPTH)); // R8

endmodule

// File: tb/spi_master_ctrl_test.sv
module spi_master_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sclk, mosi, miso, ss_n;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    assign miso = mosi;

    spi_master_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // slave model: pre-edge values from previous negedge
    logic       m_cpol = 1'b0, m_cpha = 1'b0;
    logic       p_sclk = 1'b0, p_mosi = 1'b0, p_ss = 1'b1;
    logic [7:0] cap = '0;
    logic [7:0] got [16];
    int         capbits = 0, ngot = 0, lowcnt = 0;

    always @(negedge clk) begin
        if (rst_n && sclk !== p_sclk && p_ss == 1'b0) begin
            if ((sclk != m_cpol) != m_cpha) begin
                cap = {cap[6:0], p_mosi};
                capbits++;
                if (capbits == 8) begin
                    if (ngot < 16) got[ngot] = cap;
                    ngot++;
                    capbits = 0;
                end
            end
        end
        if (rst_n && !ss_n) lowcnt++;
        p_sclk = sclk;
        p_mosi = mosi;
        p_ss   = ss_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clr_slave();
        @(posedge clk);
        ngot = 0; capbits = 0; lowcnt = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        repeat (3) @(negedge clk);
        do rd(8'h01, s); while (s[1]);
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 cfg", v, 8'h00);
        rd(8'h02, v); chk("R1 div", v, 8'hFF);
        rd(8'h01, v); chk("R1 status", v, 8'h00);
        chk("R1 ss_n", ss_n, 1); chk("R1 sclk", sclk, 0); chk("R1 irq", irq, 0);

        // R2 register map
        wr(8'h02, 8'h03); rd(8'h02, v); chk("R2 div readback", v, 3);
        wr(8'h00, 8'h1B); rd(8'h00, v); chk("R2 cfg readback", v, 8'h1B);
        rd(8'h20, v); chk("R2 unmapped", v, 0);

        // sweep: divider x mode x bit order (R3 R4 R5 R6 R7 R10)
        for (int d = 0; d < 3; d++) begin
            for (int m = 0; m < 4; m++) begin
                for (int l = 0; l < 2; l++) begin
                    b = 8'(8'h5A ^ (d * 37 + m * 11 + l * 90));
                    wr(8'h00, 8'((l << 4) | (m << 2) | 2));
                    m_cpol = m[0]; m_cpha = m[1];
                    wr(8'h02, 8'(d));
                    @(negedge clk);
                    chk("R4 idle level", sclk, m[0]);
                    clr_slave();
                    wr(8'h08, b);
                    wait_idle();
                    chk("R4/R5 slave count", ngot, 1);
                    chk("R4/R5 slave byte", got[0], l ? rev8(b) : b);
                    chk("R3/R10 select window", lowcnt, 17 << d);
                    rd(8'h01, v); chk("R6 ready set", v[0], 1);
                    chk("R7 irq set", irq, 1);
                    rd(8'h10, v); chk("R6 rx data", v, b);
                    rd(8'h01, v); chk("R6 ready clear on read", v[0], 0);
                    chk("R7 irq clear", irq, 0);
                end
            end
        end

        // R8 R9 queue depth, overflow, half flag, ordering
        m_cpol = 0; m_cpha = 0;
        wr(8'h00, 8'h01); wr(8'h02, 8'h00);
        for (int i = 0; i < 10; i++) begin
            wr(8'h08, 8'(i * 17 + 3));
            if (i == 2) begin rd(8'h01, v); chk("R9 half flag low at 3", v[2], 0); end
            if (i == 3) begin rd(8'h01, v); chk("R9 half flag at 4", v[2], 1); end
        end
        rd(8'h01, v); chk("R12 no frame while halted", v[1], 0);
        clr_slave();
        wr(8'h00, 8'h00);
        repeat (2) @(negedge clk);
        rd(8'h01, v); chk("R9 busy flag", v[1], 1);
        wait_idle();
        chk("R8 overflow dropped", ngot, 8);
        for (int i = 0; i < 8; i++) chk("R8 order", got[i], (i * 17 + 3) & 8'hFF);
        chk("R10 multi-byte window", lowcnt, 16 * 8 + 1);
        rd(8'h10, v); chk("R6 last byte", v, (7 * 17 + 3) & 8'hFF);

        // R12 disable mid-frame
        m_cpol = 1;
        wr(8'h00, 8'h04); wr(8'h02, 8'h02);
        wr(8'h08, 8'hC3); wr(8'h08, 8'h3C);
        repeat (40) @(negedge clk);
        wr(8'h00, 8'h05);
        @(negedge clk);
        chk("R12 sclk idle", sclk, 1); chk("R12 ss_n high", ss_n, 1);
        repeat (20) @(negedge clk);
        chk("R12 sclk held", sclk, 1); chk("R12 ss_n held", ss_n, 1);
        rd(8'h01, v); chk("R12 not busy", v[1], 0);
        wr(8'h00, 8'h04);
        wait_idle();
        rd(8'h01, v); chk("R6 ready after drain", v[0], 1);
        wr(8'h01, 8'h01);
        rd(8'h01, v); chk("R6 write-one clear", v[0], 0);

        // R11 manual select
        wr(8'h00, 8'h20); @(negedge clk); chk("R11 manual low", ss_n, 0);
        wr(8'h00, 8'h60); @(negedge clk); chk("R11 manual high", ss_n, 1);
        wr(8'h00, 8'h20); wr(8'h08, 8'h99);
        repeat (5) @(negedge clk); chk("R11 manual low in frame", ss_n, 0);
        wait_idle();
        wr(8'h00, 8'h00); @(negedge clk); chk("R11 auto idle high", ss_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule